// File: doc/BRIEF.md
# Flash Card Configuration and Paging Controller

This block is the control logic that sits between a card host bus and the flash devices of a linear flash memory card. The host reaches two configuration registers in attribute space. One holds a soft-reset bit and a two-bit page number. The other holds a power-down bit. The page number extends the card beyond the 64 MB window that a single host address covers. The flash devices are wired in pairs, with one device for the low byte and one for the high byte, so each pair forms a 16-bit word path.

The block decodes array accesses in common memory into per-device chip enables and passes the in-pair address through. It steers byte lanes for byte-wide accesses. It drives one active-low reset/power-down line shared by all devices, which is asserted by a hardware reset, by a soft reset or by the power-down bit. The highest page code selects a page with no memory: no device is enabled and reads return all ones. Register writes take effect on the clock edge that samples the write strobe. Chip enables, strobes and read data follow the host inputs combinationally.

Top module: `flash_page_ctrl`

## Requirements
- R1: The option register is decoded at attribute address 0x4000 and the status register at 0x4002. An attribute read of the option register returns soft-reset in bit 7, bits 6:2 as 0 and the page in bits 1:0. A read of the status register returns power-down in bit 2 and 0 elsewhere. host_rdata[15:8] is 0 on register reads. Attribute writes and reads at any other address change nothing and read 0.
- R2: Writing the option register with bit 7 = 1 enters soft reset. While soft reset is set, dev_rst_n is 0, every dev_ce_n bit is 1, dev_oe_n and dev_we_n stay 1, and array reads return 0xFFFF.
- R3: Writing the option register with bit 7 = 0 while in soft reset ends it and leaves page 0 and power-down 0, whatever the other data bits are. Status register writes during soft reset are ignored.
- R4: Outside soft reset, an option register write with bit 7 = 0 loads the page from data bits 1:0 onto page_num. Data bits 6:2 have no effect.
- R5: An array access uses pair index p = page*2 + host_addr[25]. A word access drives dev_ce_n[2p] (low-byte device) and dev_ce_n[2p+1] (high-byte device) to 0 and all other bits to 1.
- R6: A byte access (host_byte = 1) enables only the low-byte device when host_addr[0] = 0 and only the high-byte device when host_addr[0] = 1. A byte read returns the selected byte on host_rdata[7:0] with bits 15:8 at 0. A byte write places host_wdata[7:0] on both halves of dev_wdata.
- R7: Page code 3 has no memory. Array reads and writes to it assert no chip enable, dev_oe_n and dev_we_n stay 1, and reads return 0xFFFF.
- R8: Status register bit 2 written as 1 drives dev_rst_n to 0 and blocks all chip enables. Written as 0, it returns dev_rst_n to 1. The other status data bits have no effect.
- R9: hw_reset = 1 drives dev_rst_n to 0 at once, blocks register writes, and clears soft-reset, page and power-down at the next clock edge. Asserting rst_n low clears them asynchronously.
- R10: dev_addr carries host_addr[24:1]. An enabled array read drives dev_oe_n to 0 and dev_wdata is don't-care. An enabled array write drives dev_we_n to 0. A word read returns dev_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_reset | input | 1 | Card hardware reset, active high |
| host_attr | input | 1 | 1 = attribute space access, 0 = array access |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_byte | input | 1 | 1 = byte-wide access |
| host_addr | input | 26 | Host byte address within the 64 MB window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| page_num | output | 2 | Current memory page |
| dev_ce_n | output | 12 | Per-device chip enables, active low, two per pair |
| dev_addr | output | 24 | Word address inside a device pair |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_we_n | output | 1 | Device write enable, active low |
| dev_rst_n | output | 1 | Device reset/power-down, active low |
| dev_wdata | output | 16 | Data toward the devices |
| dev_rdata | input | 16 | Data from the devices |

## Verification
All state lives in three register fields, and every one of them is visible at the ports within one cycle. A wrong page shows on page_num and on the chip enables of the very next array access. A soft-reset or power-down bit that is stuck or left set shows as dev_rst_n held low and reads of 0xFFFF. A default that was not restored after a soft reset shows on the first register read-back after the clearing write. For these reasons the bench checks each register write one cycle later through register reads and array decode.

// File: rtl/fcp_pkg.sv
`timescale 1ns/1ps
package fcp_pkg;
  localparam int PG_W      = 2;
  localparam int SRST_BIT  = 7;
  localparam int PWRDN_BIT = 2;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;

  typedef struct packed {
    logic            srst;
    logic            pwrdn;
    logic [PG_W-1:0] page;
  } cfg_state_t;
endpackage

// File: rtl/fcp_rst_sync.sv
`timescale 1ns/1ps
module fcp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fcp_cfg_regs.sv
`timescale 1ns/1ps
module fcp_cfg_regs
  import fcp_pkg::*;
#(
  parameter int          ADDR_W    = 26,
  parameter int unsigned OPT_ADDR  = 'h4000,
  parameter int unsigned STAT_ADDR = 'h4002
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_reset,
  input  logic                host_attr,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [BYTE_W-1:0]   wdata,
  output cfg_state_t          cfg,
  output logic [BYTE_W-1:0]   reg_rdata
);
  localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic       hit_opt, hit_stat;
  logic       wr_opt, wr_stat;
  logic       cfg_en;
  cfg_state_t cfg_nxt;

  assign hit_opt  = host_attr && (host_addr == OPT_A);
  assign hit_stat = host_attr && (host_addr == STAT_A);
  assign wr_opt   = host_wr && hit_opt;
  assign wr_stat  = host_wr && hit_stat;
  assign cfg_en   = hw_reset || wr_opt || wr_stat;

  // next-state
  always_comb begin
    cfg_nxt = cfg;
    if (hw_reset) begin
      cfg_nxt = '0;
    end else if (wr_opt) begin
      cfg_nxt.srst = wdata[SRST_BIT];
      if (wdata[SRST_BIT] || cfg.srst) begin
        cfg_nxt.page  = '0;
        cfg_nxt.pwrdn = 1'b0;
      end else begin
        cfg_nxt.page = wdata[PG_W-1:0];
      end
    end else if (wr_stat && !cfg.srst) begin
      cfg_nxt.pwrdn = wdata[PWRDN_BIT];
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_en) cfg <= cfg_nxt;
  end

  // read-back
  always_comb begin
    reg_rdata = '0;
    if (host_rd && hit_opt) begin
      reg_rdata[SRST_BIT]   = cfg.srst;
      reg_rdata[PG_W-1:0]   = cfg.page;
    end else if (host_rd && hit_stat) begin
      reg_rdata[PWRDN_BIT]  = cfg.pwrdn;
    end
  end

  a_r3_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.srst |-> (cfg.page == '0) && !cfg.pwrdn);

  a_r9_hw_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |=> (cfg == '0));

  a_r3_stat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && cfg.srst && !hw_reset) |=> !cfg.pwrdn);

  a_r4_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opt && !cfg.srst && !wdata[SRST_BIT] && !hw_reset)
      |=> (cfg.page == $past(wdata[PG_W-1:0])));
endmodule

// File: rtl/fcp_ce_decode.sv
`timescale 1ns/1ps
module fcp_ce_decode
  import fcp_pkg::*;
#(
  parameter int NUM_PAGES = 3,
  parameter int SEL_W     = 1,
  localparam int PAIRS_PER_PAGE = 1 << SEL_W,
  localparam int NUM_PAIRS      = NUM_PAGES * PAIRS_PER_PAGE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   access_en,
  input  logic [PG_W-1:0]        page,
  input  logic [SEL_W-1:0]       pair_sel,
  input  logic                   byte_mode,
  input  logic                   odd,
  output logic [2*NUM_PAIRS-1:0] ce_n
);
  logic [31:0] tgt;
  logic        page_ok;
  logic        lo_lane, hi_lane;

  always_comb begin
    tgt = 32'(page) * 32'(PAIRS_PER_PAGE) + 32'(pair_sel);
  end

  assign page_ok = 32'(page) < 32'(NUM_PAGES);
  assign lo_lane = !byte_mode || !odd;
  assign hi_lane = !byte_mode || odd;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic hit;
    assign hit           = access_en && page_ok && (tgt == 32'(p));
    assign ce_n[2*p]     = !(hit && lo_lane);
    assign ce_n[2*p+1]   = !(hit && hi_lane);
  end

  a_r7_dead_page: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(page) >= 32'(NUM_PAGES)) |-> (&ce_n));

  a_r5_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 2);

  a_r6_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> $countones(~ce_n) <= 1);
endmodule

// File: rtl/flash_page_ctrl.sv
`timescale 1ns/1ps
module flash_page_ctrl
  import fcp_pkg::*;
#(
  parameter int          HOST_AW   = 26,
  parameter int          PAIR_AW   = 25,
  parameter int          NUM_PAGES = 3,
  parameter int unsigned OPT_ADDR  = 'h4000,
  parameter int unsigned STAT_ADDR = 'h4002,
  localparam int SEL_W     = HOST_AW - PAIR_AW,
  localparam int NUM_PAIRS = NUM_PAGES * (1 << SEL_W),
  localparam int CE_W      = 2 * NUM_PAIRS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_reset,
  input  logic               host_attr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic               host_byte,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  output logic [PG_W-1:0]    page_num,
  output logic [CE_W-1:0]    dev_ce_n,
  output logic [PAIR_AW-2:0] dev_addr,
  output logic               dev_oe_n,
  output logic               dev_we_n,
  output logic               dev_rst_n,
  output logic [WORD_W-1:0]  dev_wdata,
  input  logic [WORD_W-1:0]  dev_rdata
);
  logic              rst_n_s;
  cfg_state_t        cfg;
  logic [BYTE_W-1:0] reg_rdata;
  logic              dev_hold, page_ok, arr_req, arr_en, rd_en, wr_en;
  logic              odd;

  fcp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  fcp_cfg_regs #(
    .ADDR_W    (HOST_AW),
    .OPT_ADDR  (OPT_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hw_reset  (hw_reset),
    .host_attr (host_attr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .wdata     (host_wdata[BYTE_W-1:0]),
    .cfg       (cfg),
    .reg_rdata (reg_rdata)
  );

  assign odd      = host_addr[0];
  assign dev_hold = hw_reset || cfg.srst || cfg.pwrdn || !rst_n_s;
  assign page_ok  = 32'(cfg.page) < 32'(NUM_PAGES);
  assign arr_req  = !host_attr && (host_rd || host_wr);
  assign arr_en   = arr_req && !dev_hold && page_ok;
  assign rd_en    = arr_en && host_rd && !host_wr;
  assign wr_en    = arr_en && host_wr;

  fcp_ce_decode #(
    .NUM_PAGES (NUM_PAGES),
    .SEL_W     (SEL_W)
  ) u_ce (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .access_en (arr_en),
    .page      (cfg.page),
    .pair_sel  (host_addr[HOST_AW-1:PAIR_AW]),
    .byte_mode (host_byte),
    .odd       (odd),
    .ce_n      (dev_ce_n)
  );

  assign dev_rst_n = !dev_hold;
  assign dev_oe_n  = !rd_en;
  assign dev_we_n  = !wr_en;
  assign dev_addr  = host_addr[PAIR_AW-1:1];
  assign page_num  = cfg.page;
  assign dev_wdata = host_byte ? {2{host_wdata[BYTE_W-1:0]}} : host_wdata;

  always_comb begin
    host_rdata = '0;
    if (host_attr && host_rd) begin
      host_rdata[BYTE_W-1:0] = reg_rdata;
    end else if (arr_req && host_rd && !host_wr) begin
      if (!rd_en)        host_rdata = '1;
      else if (host_byte) host_rdata[BYTE_W-1:0] = odd ? dev_rdata[WORD_W-1:BYTE_W]
                                                       : dev_rdata[BYTE_W-1:0];
      else               host_rdata = dev_rdata;
    end
  end

  a_r2_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dev_rst_n |-> (&dev_ce_n) && dev_oe_n && dev_we_n);

  a_r9_hw_ce_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    hw_reset |-> (&dev_ce_n));

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!dev_oe_n && !dev_we_n));

  a_r7_dead_ones: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!host_attr && host_rd && !host_wr && (&dev_ce_n)) |-> (host_rdata == '1));
endmodule

// File: tb/flash_page_ctrl_test.sv
`timescale 1ns/1ps
module flash_page_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n, hw_reset, host_attr, host_rd, host_wr, host_byte;
  logic [25:0] host_addr;
  logic [15:0] host_wdata, host_rdata, dev_wdata, dev_rdata;
  logic [1:0]  page_num;
  logic [11:0] dev_ce_n;
  logic [23:0] dev_addr;
  logic        dev_oe_n, dev_we_n, dev_rst_n;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_page_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .host_attr(host_attr),
    .host_rd(host_rd), .host_wr(host_wr), .host_byte(host_byte),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .page_num(page_num), .dev_ce_n(dev_ce_n), .dev_addr(dev_addr),
    .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n), .dev_rst_n(dev_rst_n),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ce_word(input int p);
    return ~(12'd3 << (2 * p));
  endfunction

  function automatic logic [11:0] ce_one(input int dev);
    return ~(12'd1 << dev);
  endfunction

  task automatic idle();
    @(negedge clk);
    host_attr = 0; host_rd = 0; host_wr = 0; host_byte = 0;
    host_addr = '0; host_wdata = '0;
  endtask

  task automatic reg_wr(input logic [25:0] a, input logic [7:0] d);
    @(negedge clk);
    host_attr = 1; host_wr = 1; host_rd = 0; host_addr = a; host_wdata = {8'h00, d};
    idle();
  endtask

  task automatic reg_rd(input logic [25:0] a, output logic [15:0] d);
    @(negedge clk);
    host_attr = 1; host_rd = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    idle();
  endtask

  task automatic arr_drive(input bit wr, input bit byt,
                           input logic [25:0] a, input logic [15:0] d);
    @(negedge clk);
    host_attr = 0; host_rd = !wr; host_wr = wr; host_byte = byt;
    host_addr = a; host_wdata = d;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R9", "page after reset", page_num, 0);
    chk("R9", "dev_rst_n after reset", dev_rst_n, 1);
    chk("R9", "ce idle", dev_ce_n, 12'hFFF);
    reg_rd(26'h4000, d); chk("R1", "opt reset value", d, 0);
    reg_rd(26'h4002, d); chk("R1", "stat reset value", d, 0);
  endtask

  task automatic t_word_page();
    logic [15:0] d;
    logic [25:0] a;
    reg_wr(26'h4000, 8'h01);
    chk("R4", "page_num", page_num, 1);
    reg_rd(26'h4000, d); chk("R1", "opt readback", d, 16'h0001);
    a = {1'b1, 25'h0012346};
    arr_drive(0, 0, a, 16'h0);
    chk("R5", "word read ce pair 3", dev_ce_n, ce_word(3));
    chk("R10", "oe low", dev_oe_n, 0);
    chk("R10", "we high", dev_we_n, 1);
    chk("R10", "dev_addr", dev_addr, a[24:1]);
    chk("R10", "word rdata", host_rdata, 16'hA55A);
    idle();
    a = {1'b0, 25'h0000100};
    arr_drive(1, 0, a, 16'h1234);
    chk("R5", "word write ce pair 2", dev_ce_n, ce_word(2));
    chk("R10", "we low", dev_we_n, 0);
    chk("R10", "word wdata", dev_wdata, 16'h1234);
    idle();
  endtask

  task automatic t_bytes();
    reg_wr(26'h4000, 8'h02);
    arr_drive(0, 1, 26'h0000011, 16'h0);
    chk("R6", "odd byte ce", dev_ce_n, ce_one(9));
    chk("R6", "odd byte rdata", host_rdata, 16'h00A5);
    idle();
    arr_drive(0, 1, 26'h0000010, 16'h0);
    chk("R6", "even byte ce", dev_ce_n, ce_one(8));
    chk("R6", "even byte rdata", host_rdata, 16'h005A);
    idle();
    arr_drive(1, 1, 26'h2000010, 16'hEE3C);
    chk("R6", "byte write ce", dev_ce_n, ce_one(10));
    chk("R6", "byte write data", dev_wdata, 16'h3C3C);
    idle();
  endtask

  task automatic t_dead_page();
    reg_wr(26'h4000, 8'h03);
    chk("R7", "page 3", page_num, 3);
    arr_drive(0, 0, 26'h2000000, 16'h0);
    chk("R7", "dead read ce", dev_ce_n, 12'hFFF);
    chk("R7", "dead read data", host_rdata, 16'hFFFF);
    chk("R7", "dead oe", dev_oe_n, 1);
    idle();
    arr_drive(1, 0, 26'h0000000, 16'h5555);
    chk("R7", "dead write ce", dev_ce_n, 12'hFFF);
    chk("R7", "dead we", dev_we_n, 1);
    idle();
  endtask

  task automatic t_unused_bits();
    logic [15:0] d;
    reg_wr(26'h4000, 8'h7D);
    reg_rd(26'h4000, d); chk("R4", "unused opt bits", d, 16'h0001);
    reg_wr(26'h4002, 8'hFB);
    reg_rd(26'h4002, d); chk("R8", "stat other bits ignored", d, 0);
    chk("R8", "dev_rst_n stays", dev_rst_n, 1);
    reg_wr(26'h4002, 8'h04);
    reg_rd(26'h4002, d); chk("R1", "stat readback", d, 16'h0004);
    chk("R8", "pwrdn drives reset", dev_rst_n, 0);
    arr_drive(0, 0, 26'h0, 16'h0);
    chk("R8", "pwrdn blocks ce", dev_ce_n, 12'hFFF);
    idle();
    reg_wr(26'h4002, 8'h00);
    chk("R8", "pwrdn released", dev_rst_n, 1);
  endtask

  task automatic t_soft_reset();
    logic [15:0] d;
    reg_wr(26'h4000, 8'h02);
    reg_wr(26'h4000, 8'h82);
    reg_rd(26'h4000, d); chk("R2", "srst readback", d, 16'h0080);
    chk("R2", "srst clears page", page_num, 0);
    chk("R2", "srst dev_rst_n", dev_rst_n, 0);
    arr_drive(0, 0, 26'h0, 16'h0);
    chk("R2", "srst ce", dev_ce_n, 12'hFFF);
    chk("R2", "srst read ones", host_rdata, 16'hFFFF);
    idle();
    reg_wr(26'h4002, 8'h04);
    reg_rd(26'h4002, d); chk("R3", "stat write ignored in srst", d, 0);
    reg_wr(26'h4000, 8'h02);
    reg_rd(26'h4000, d); chk("R3", "srst exit defaults", d, 0);
    chk("R3", "dev_rst_n after exit", dev_rst_n, 1);
  endtask

  task automatic t_other_addr();
    logic [15:0] d;
    reg_wr(26'h4000, 8'h01);
    reg_wr(26'h4004, 8'h83);
    reg_wr(26'h0000, 8'h86);
    reg_rd(26'h4000, d); chk("R1", "opt unchanged", d, 16'h0001);
    reg_rd(26'h4002, d); chk("R1", "stat unchanged", d, 0);
    reg_rd(26'h4004, d); chk("R1", "other addr reads 0", d, 0);
  endtask

  task automatic t_hw_reset();
    logic [15:0] d;
    reg_wr(26'h4000, 8'h02);
    reg_wr(26'h4002, 8'h04);
    reg_wr(26'h4002, 8'h00);
    @(negedge clk);
    hw_reset = 1;
    #1 chk("R9", "hw reset drives dev_rst_n", dev_rst_n, 0);
    host_attr = 1; host_wr = 1; host_addr = 26'h4000; host_wdata = 16'h0001;
    idle();
    chk("R9", "hw reset clears page", page_num, 0);
    hw_reset = 0;
    #1 chk("R9", "dev_rst_n after hw", dev_rst_n, 1);
    reg_rd(26'h4000, d); chk("R9", "opt after hw", d, 0);
  endtask

  task automatic t_por();
    reg_wr(26'h4000, 8'h01);
    chk("R9", "page before por", page_num, 1);
    @(negedge clk);
    #1 rst_n = 0;
    #0.5 chk("R9", "async clear", page_num, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R9", "dev_rst_n after por", dev_rst_n, 1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; hw_reset = 0; host_attr = 0; host_rd = 0; host_wr = 0;
    host_byte = 0; host_addr = '0; host_wdata = '0; dev_rdata = 16'hA55A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word_page();
    t_bytes();
    t_dead_page();
    t_unused_bits();
    t_soft_reset();
    t_other_addr();
    t_hw_reset();
    t_por();
    done = 1;
    finish_run();
  end
endmodule